// File: doc/BRIEF.md
# Trace Buffer Register Port over JTAG

This block lets a debugger reach the control and status registers of an on-chip trace buffer through the test access port. The debugger first loads the chain-select instruction and shifts a 5-bit chain number. Chain 0 is the trace buffer register chain. The debugger then loads the register-access instruction. From that point every data scan moves a 40-bit word. The word holds a 32-bit data field, a 7-bit register address and a direction flag.

A write scan produces a one-cycle write strobe toward the addressed register during Update-DR. A read scan only records the address. The register's value is loaded into the data field at the next Capture-DR and shifts out during the following scan, so every read costs two scans.

Address 4 is the window onto the trace RAM. Each value returned from it raises a pop pulse, which the buffer uses to advance its read pointer. A burst read therefore repeats address 4 and names address 0, the identification register, on its last scan. This fetches the final word without using up another entry. The TAP controller, the registers themselves and the trace RAM are outside the block. The block takes the decoded TAP state flags and the current instruction as inputs, and runs in the TCK domain.

Top module: `trb_jtag_port`

## Requirements
- R1: A synchronous active-low reset sets the selected chain to 5'h1F, clears any pending read, and holds `wr_en` and `ram_pop` at zero.
- R2: Register access is active only when the instruction is 4'hC and the selected chain is 0. With any other instruction or chain, a scan raises no write strobe and no pop.
- R3: The chain number is loaded under instruction 4'h2 through a 5-bit register shifted least significant bit first and applied at Update-DR. At Capture-DR that register loads the chain number currently in force.
- R4: The access word is 40 bits, shifted least significant bit first. Bits [31:0] are data, bits [38:32] are the register address, and bit 39 is the direction (1 = write, 0 = read).
- R5: A write scan to an address from 0 to 8 drives `wr_en` one-hot with bit `addr` set, and drives `wr_data` with bits [31:0], for exactly the Update-DR cycle.
- R6: A write scan to an address from 9 to 127 raises no bit of `wr_en`.
- R7: A read scan records its address. The next Capture-DR loads that register's value into bits [31:0] and zero into bits [39:32], so the value appears on `tdo` during the following scan.
- R8: A read of an address from 9 to 127 returns zero in the data field.
- R9: When a read of address 4 is returned, `ram_pop` is high for the single Capture-DR cycle. Each read scan of address 4 gives exactly one pop, and a read of address 0 gives none.
- R10: A Capture-DR that does not follow a read scan returns zero and raises no pop. This covers a capture after a write scan and a second capture.
- R11: When the access path and the chain-select path are both inactive, `tdo` comes from a 1-bit bypass stage that captures 0. A scan then reads back its input delayed by one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCK-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir | input | 4 | Instruction currently in force |
| capture_dr | input | 1 | TAP is in Capture-DR this cycle |
| shift_dr | input | 1 | TAP is in Shift-DR this cycle |
| update_dr | input | 1 | TAP is in Update-DR this cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the active path |
| wr_en | output | 9 | One-hot register write strobe |
| wr_data | output | 32 | Write data for the strobed register |
| reg_rdata | input | 288 | Read values of the nine registers, register i at bits [32*i+31:32*i] |
| ram_pop | output | 1 | Advance the trace RAM read pointer |

## Verification
A wrong recorded read address or a stale pending flag shows up one full scan after the faulty read. The data field then shifts out the wrong register's value, a nonzero value where zero belongs, or it carries an extra or missing `ram_pop` that moves every later burst word by one entry. A faulty chain latch or path select appears within the same scan, as a strobe that should be absent or as bypass data on `tdo`. Field position errors appear at once, as a wrong strobe bit or wrong `wr_data` in that scan's Update-DR cycle.

// File: rtl/trb_pkg.sv
// Package: shared constants and the output path selector for the trace
// buffer register port. Assumes a 4-bit instruction register.
package trb_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 7;
    localparam int unsigned CHAIN_W = 5;
    localparam int unsigned IR_W    = 4;
    localparam int unsigned NREG    = 9;

    // Which serial path drives tdo
    typedef enum logic [1:0] {
        PATH_BYPASS = 2'd0,
        PATH_CHAIN  = 2'd1,
        PATH_ACCESS = 2'd2
    } path_e;
endpackage

// File: rtl/trb_chain_sel.sv
// Chain select register: a CHAIN_W shift stage used under the chain-select
// instruction. Captures the chain in force, applies the new one on update.
// Assumes the TAP flags are mutually exclusive.
module trb_chain_sel #(
    parameter int unsigned CHAIN_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic               so,
    output logic [CHAIN_W-1:0] chain
);
    logic [CHAIN_W-1:0] sr;

    // Shift stage: capture current chain, shift LSB first
    always_ff @(posedge clk) begin
        if (!rst_n)                 sr <= '0;
        else if (sel && capture_dr) sr <= chain;
        else if (sel && shift_dr)   sr <= {tdi, sr[CHAIN_W-1:1]};
    end

    // Chain latch: applied at Update-DR, parked at all-ones after reset
    always_ff @(posedge clk) begin
        if (!rst_n)                chain <= '1;
        else if (sel && update_dr) chain <= sr;
    end

    assign so = sr[0];

    assert_chain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && update_dr) |=> $stable(chain));
endmodule

// File: rtl/trb_access_dr.sv
// Access data register: the DR_W shift stage used for register scans.
// Loads the returned word at capture and exposes the fields at update.
// Assumes act is stable across one scan.
module trb_access_dr #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 7,
    localparam int unsigned DR_W  = DATA_W + ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              tdi,
    output logic              so,
    output logic [DATA_W-1:0] f_data,
    output logic [ADDR_W-1:0] f_addr,
    output logic              f_wr
);
    logic [DR_W-1:0] sr;

    // Shift stage: capture data field with zeroed address/direction, shift LSB first
    always_ff @(posedge clk) begin
        if (!rst_n)                 sr <= '0;
        else if (act && capture_dr) sr <= {{(ADDR_W+1){1'b0}}, cap_data};
        else if (act && shift_dr)   sr <= {tdi, sr[DR_W-1:1]};
    end

    assign so     = sr[0];
    assign f_data = sr[DATA_W-1:0];
    assign f_addr = sr[DATA_W +: ADDR_W];
    assign f_wr   = sr[DR_W-1];

    assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act && shift_dr && !capture_dr) |=> (f_wr == $past(tdi)));
endmodule

// File: rtl/trb_reg_decode.sv
// Register decode: turns update events into one-hot write strobes, records
// read addresses, and at capture muxes the recorded register back with a
// RAM pop for the data window. Assumes upd and cap never coincide.
module trb_reg_decode #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned NREG     = 9,
    parameter int unsigned RAM_ADDR = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd,
    input  logic                   cap,
    input  logic                   f_wr,
    input  logic [ADDR_W-1:0]      f_addr,
    input  logic [DATA_W-1:0]      f_data,
    input  logic [NREG*DATA_W-1:0] reg_rdata,
    output logic [NREG-1:0]        wr_en,
    output logic [DATA_W-1:0]      wr_data,
    output logic [DATA_W-1:0]      cap_data,
    output logic                   ram_pop
);
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_pend;
    logic              rd_hit;

    // Write strobes: one bit per mapped register, only during Update-DR
    for (genvar g = 0; g < NREG; g++) begin : g_wr
        assign wr_en[g] = upd && f_wr && (f_addr == ADDR_W'(g));
    end
    assign wr_data = f_data;

    // Read bookkeeping: record address on a read update, consume at capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
            rd_pend <= 1'b0;
        end else if (upd) begin
            rd_addr <= f_addr;
            rd_pend <= !f_wr;
        end else if (cap) begin
            rd_pend <= 1'b0;
        end
    end

    // Return mux: selected register, zero when unmapped or nothing pending
    always_comb begin
        cap_data = '0;
        rd_hit   = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_pend && rd_addr == ADDR_W'(i)) begin
                cap_data = reg_rdata[i*DATA_W +: DATA_W];
                rd_hit   = 1'b1;
            end
        end
    end

    assign ram_pop = cap && rd_hit && (rd_addr == ADDR_W'(RAM_ADDR));

    assert_wr_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
    assert_wr_in_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> upd);
    assert_pop_in_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_pop |-> cap);
    assert_pop_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_pop |=> !ram_pop);
endmodule

// File: rtl/trb_jtag_port.sv
// Top: trace buffer register port. Picks the serial path from the current
// instruction and chain, gates TAP flags into the chain select register and
// the access register, and owns the bypass stage. Assumes one TAP flag at a
// time and an instruction that is stable during data scans.
module trb_jtag_port
    import trb_pkg::*;
#(
    parameter int unsigned  DATA_W      = trb_pkg::DATA_W,
    parameter int unsigned  ADDR_W      = trb_pkg::ADDR_W,
    parameter int unsigned  CHAIN_W     = trb_pkg::CHAIN_W,
    parameter int unsigned  IR_W        = trb_pkg::IR_W,
    parameter int unsigned  NREG        = trb_pkg::NREG,
    parameter int unsigned  RAM_ADDR    = 4,
    parameter logic [3:0]   OP_CHAIN    = 4'h2,
    parameter logic [3:0]   OP_ACCESS   = 4'hC,
    parameter int unsigned  TRACE_CHAIN = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IR_W-1:0]        ir,
    input  logic                   capture_dr,
    input  logic                   shift_dr,
    input  logic                   update_dr,
    input  logic                   tdi,
    output logic                   tdo,
    output logic [NREG-1:0]        wr_en,
    output logic [DATA_W-1:0]      wr_data,
    input  logic [NREG*DATA_W-1:0] reg_rdata,
    output logic                   ram_pop
);
    logic [CHAIN_W-1:0] chain;
    logic               chain_so, acc_so, byp;
    logic               sel_chain, acc_act;
    logic [DATA_W-1:0]  cap_data, f_data;
    logic [ADDR_W-1:0]  f_addr;
    logic               f_wr;
    path_e              path;

    assign sel_chain = (ir == IR_W'(OP_CHAIN));
    assign acc_act   = (ir == IR_W'(OP_ACCESS)) && (chain == CHAIN_W'(TRACE_CHAIN));

    // Path select for tdo
    always_comb begin
        if (sel_chain)    path = PATH_CHAIN;
        else if (acc_act) path = PATH_ACCESS;
        else              path = PATH_BYPASS;
    end

    trb_chain_sel #(.CHAIN_W(CHAIN_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .sel(sel_chain),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .so(chain_so), .chain(chain)
    );

    trb_access_dr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dr (
        .clk(clk), .rst_n(rst_n), .act(acc_act),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .cap_data(cap_data),
        .tdi(tdi), .so(acc_so), .f_data(f_data), .f_addr(f_addr), .f_wr(f_wr)
    );

    trb_reg_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG),
                     .RAM_ADDR(RAM_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .upd(acc_act && update_dr), .cap(acc_act && capture_dr),
        .f_wr(f_wr), .f_addr(f_addr), .f_data(f_data), .reg_rdata(reg_rdata),
        .wr_en(wr_en), .wr_data(wr_data), .cap_data(cap_data), .ram_pop(ram_pop)
    );

    // Bypass stage: captures 0, shifts tdi when no other path is active
    always_ff @(posedge clk) begin
        if (!rst_n)                                    byp <= 1'b0;
        else if (path == PATH_BYPASS && capture_dr)    byp <= 1'b0;
        else if (path == PATH_BYPASS && shift_dr)      byp <= tdi;
    end

    // Serial output mux
    always_comb begin
        unique case (path)
            PATH_CHAIN:  tdo = chain_so;
            PATH_ACCESS: tdo = acc_so;
            default:     tdo = byp;
        endcase
    end

    assert_idle_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_act |-> (wr_en == '0 && !ram_pop));
endmodule

// File: tb/tb_trb_jtag_port.sv
module tb_trb_jtag_port;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   ir = 4'h0;
    logic         capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic         tdo;
    logic [8:0]   wr_en;
    logic [31:0]  wr_data;
    logic [287:0] reg_rdata;
    logic         ram_pop;

    int n_chk = 0, n_fail = 0;
    logic [31:0] regs [9];
    int          ptr;
    int          pops;

    always #10 clk = ~clk;

    trb_jtag_port dut (
        .clk(clk), .rst_n(rst_n), .ir(ir), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .wr_en(wr_en), .wr_data(wr_data), .reg_rdata(reg_rdata), .ram_pop(ram_pop)
    );

    function automatic logic [31:0] ram_word(int p);
        return 32'hC0DE_0000 + 32'(p);
    endfunction

    // Bench-side register bus: stores strobed writes, serves reads, pops RAM
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) regs[i] <= 32'h0;
            ptr  <= 0;
            pops <= 0;
        end else begin
            for (int i = 0; i < 9; i++) if (wr_en[i]) regs[i] <= wr_data;
            if (ram_pop) begin
                ptr  <= ptr + 1;
                pops <= pops + 1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < 9; i++)
            reg_rdata[i*32 +: 32] = (i == 4) ? ram_word(ptr) : regs[i];
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chain_scan(input logic [4:0] din, output logic [4:0] dout);
        ir = 4'h2;
        @(negedge clk); capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tdi = din[i]; #1 dout[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0; tdi = 1'b0; update_dr = 1'b1;
        @(negedge clk); update_dr = 1'b0;
    endtask

    task automatic dr_scan(input logic [39:0] din, output logic [39:0] dout,
                           output logic [8:0] wen, output logic [31:0] wdat);
        @(negedge clk); capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tdi = din[i]; #1 dout[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0; tdi = 1'b0; update_dr = 1'b1;
        #1 wen = wr_en; wdat = wr_data;
        @(negedge clk); update_dr = 1'b0;
    endtask

    function automatic logic [39:0] word(input bit wr, input logic [6:0] a, input logic [31:0] d);
        return {wr, a, d};
    endfunction

    function automatic logic [31:0] pat(int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'h0000_3C00;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [4:0]  c_out;
        logic [39:0] d_out;
        logic [8:0]  wen;
        logic [31:0] wdat;
        int          p0, pc;
        repeat (3) @(negedge clk);
        // R1: outputs idle during and after reset
        chk(wr_en == 9'h0 && !ram_pop, "R1", {wr_en, ram_pop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 9'h0 && !ram_pop, "R1", {wr_en, ram_pop}, 0);

        // R3/R1: chain readback is the reset value, then the new chain
        chain_scan(5'd0, c_out);
        chk(c_out == 5'h1F, "R1 R3 chain reset", c_out, 5'h1F);
        chain_scan(5'd0, c_out);
        chk(c_out == 5'h00, "R3 chain readback", c_out, 0);
        ir = 4'hC;

        // R4/R5: write sweep over mapped addresses
        for (int a = 0; a < 9; a++) begin
            dr_scan(word(1'b1, 7'(a), pat(a)), d_out, wen, wdat);
            chk(wen == 9'(1 << a), "R5 R4 strobe", wen, 9'(1 << a));
            chk(wdat == pat(a), "R5 R4 data", wdat, pat(a));
        end

        // R7: read sweep, each value appears one scan later
        dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
        chk(d_out[31:0] == 32'h0, "R10 capture after write", d_out, 0);
        for (int a = 1; a < 9; a++) begin
            if (a == 4) continue;
            dr_scan(word(1'b0, 7'(a), 32'h0), d_out, wen, wdat);
            chk(wen == 9'h0, "R7 read no strobe", wen, 0);
            if (a == 1) chk(d_out == {8'h0, pat(0)}, "R7 read addr 0", d_out, {8'h0, pat(0)});
        end
        begin
            int prev;
            prev = 0;
            dr_scan(word(1'b0, 7'd1, 32'h0), d_out, wen, wdat);
            chk(d_out == {8'h0, pat(8)}, "R7 read addr 8", d_out, {8'h0, pat(8)});
            for (int a = 2; a < 9; a++) begin
                if (a == 4) continue;
                if (prev == 0) prev = 1;
                dr_scan(word(1'b0, 7'(a), 32'h0), d_out, wen, wdat);
                chk(d_out == {8'h0, pat(prev)}, "R7 chained read", d_out, {8'h0, pat(prev)});
                prev = a;
            end
            dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
            chk(d_out == {8'h0, pat(8)}, "R7 last read", d_out, {8'h0, pat(8)});
        end

        // R8: reads of every unmapped address return zero
        dr_scan(word(1'b0, 7'd9, 32'h0), d_out, wen, wdat);
        for (int a = 10; a < 129; a++) begin
            dr_scan(word(1'b0, 7'(a % 128), 32'h0), d_out, wen, wdat);
            chk(d_out == 40'h0, "R8 unmapped read", d_out, 0);
        end
        dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
        chk(d_out == {8'h0, pat(0)}, "R8 back to mapped", d_out, {8'h0, pat(0)});

        // R6: writes to every unmapped address raise no strobe
        for (int a = 9; a < 128; a++) begin
            dr_scan(word(1'b1, 7'(a), 32'hFFFF_FFFF), d_out, wen, wdat);
            chk(wen == 9'h0, "R6 unmapped write", wen, 0);
        end

        // R9: burst of five RAM reads ending on address 0
        dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
        p0 = ptr; pc = pops;
        for (int k = 0; k < 5; k++) begin
            dr_scan(word(1'b0, 7'd4, 32'h0), d_out, wen, wdat);
            if (k > 0) chk(d_out == {8'h0, ram_word(p0 + k - 1)}, "R9 burst word", d_out, {8'h0, ram_word(p0 + k - 1)});
        end
        dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
        chk(d_out == {8'h0, ram_word(p0 + 4)}, "R9 final word", d_out, {8'h0, ram_word(p0 + 4)});
        dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
        chk(d_out == {8'h0, pat(0)}, "R9 id after burst", d_out, {8'h0, pat(0)});
        chk(pops - pc == 5, "R9 pop count", pops - pc, 5);

        // R10: capture after a write to the RAM window returns zero, no pop
        dr_scan(word(1'b0, 7'd4, 32'h0), d_out, wen, wdat);
        pc = pops;
        dr_scan(word(1'b1, 7'd4, 32'h1234_5678), d_out, wen, wdat);
        chk(pops - pc == 1, "R9 single pop", pops - pc, 1);
        pc = pops;
        dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
        chk(d_out == 40'h0, "R10 zero after write", d_out, 0);
        chk(pops == pc, "R10 no pop after write", pops, pc);
        // R10: second capture without a new read
        @(negedge clk); capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0;
        @(negedge clk); capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0;
        dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
        chk(d_out == 40'h0, "R10 second capture", d_out, 0);

        // R2/R11: chain 3 blocks access; bypass delays by one bit
        chain_scan(5'd3, c_out);
        ir = 4'hC;
        dr_scan(word(1'b1, 7'd1, 32'hA5A5_0F0F), d_out, wen, wdat);
        chk(wen == 9'h0, "R2 wrong chain", wen, 0);
        chk(d_out == {word(1'b1, 7'd1, 32'hA5A5_0F0F)[38:0], 1'b0}, "R11 bypass",
            d_out, {word(1'b1, 7'd1, 32'hA5A5_0F0F)[38:0], 1'b0});

        // R2: chain 0 but a different instruction
        chain_scan(5'd0, c_out);
        chk(c_out == 5'd3, "R3 readback 3", c_out, 3);
        ir = 4'hF;
        dr_scan(word(1'b1, 7'd2, 32'h0BAD_0BAD), d_out, wen, wdat);
        chk(wen == 9'h0, "R2 wrong instruction", wen, 0);
        ir = 4'hC;
        dr_scan(word(1'b0, 7'd2, 32'h0), d_out, wen, wdat);
        dr_scan(word(1'b0, 7'd0, 32'h0), d_out, wen, wdat);
        chk(d_out == {8'h0, pat(2)}, "R2 register kept", d_out, {8'h0, pat(2)});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule